// File: doc/BRIEF.md
# Serial Slave Configuration Loader

This block loads a programmable device through its serial slave configuration port. It pulls bytes one at a time from a local byte source, such as a small memory or a host FIFO, and turns them into a configuration clock and a data line. It watches the two open-drain status lines of the target. The first is the active-low initialisation line. The second is the completion line. Neither is ever driven by the block. Both pass through a synchroniser before use.

A load begins on a single-cycle start pulse. The block then waits for the target to release its initialisation line. The leading bits of the stream hold a header, and the block reads the stream's length in bits from that header while shifting it. It shifts exactly that many bits. After that it keeps toggling the clock with the data line held high until the completion line rises. A bit-order select chooses whether each byte leaves least- or most-significant bit first. Three sticky outcome flags report the result: completion, an initialisation fault, or a startup timeout.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the clock output is low, the data output is high, no byte is requested, and busy and all three outcome flags are low.
- R2: After start, no rising clock edge occurs and no byte is requested while the synchronised initialisation line is low. Busy is high during this wait.
- R3: With `lsb_first` = 1, bit 0 of each source byte is shifted first. With `lsb_first` = 0, bit 7 is shifted first. The select is captured at start.
- R4: The serial stream holds 0xFF in bits 0–7, a 4-bit field of value 2 in bits 8–11, a 24-bit length sent MSB first in bits 12–35, and 0xF in bits 36–39. The length L counts bits. Exactly max(L, 40) data bits are shifted, and exactly ceil(max(L,40)/8) bytes are taken from the source. Leftover bits of the final byte are never shifted.
- R5: The data line changes only while the clock is low. It is stable for at least HALF_CYC full cycles before each rising edge. Each clock phase lasts HALF_CYC cycles.
- R6: If the source has no byte ready, the clock is held low and no bit is lost or repeated.
- R7: After the last data bit, the clock keeps toggling with the data line at 1 until the completion line is seen high. Once it is seen, no further rising edge occurs, `done` is set and busy falls. A completion line already high when data ends gives zero extra clocks.
- R8: If the initialisation line goes low during shifting or startup, clocking stops with the clock low, `init_error` is set, and busy falls.
- R9: If `startup_limit` startup rising edges have passed and the completion line is still low, `timeout` is set and clocking stops. A limit of 0 gives no startup edges.
- R10: The outcome flags are mutually exclusive. They stay set until the next accepted start, which clears them. A start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a load |
| lsb_first | input | 1 | 1: least-significant bit of each byte first |
| startup_limit | input | LIMIT_W | Maximum startup clocks after the data |
| src_valid | input | 1 | Source has a byte on `src_data` |
| src_data | input | 8 | Next configuration byte |
| src_ready | output | 1 | Block takes the byte this cycle if valid |
| cfg_init_n | input | 1 | Target initialisation line, pulled up, low = not ready / fault |
| cfg_done | input | 1 | Target completion line, pulled up |
| cfg_cclk | output | 1 | Configuration clock to the target |
| cfg_din | output | 1 | Serial configuration data |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load completed |
| init_error | output | 1 | Last load stopped on an initialisation fault |
| timeout | output | 1 | Last load ran out of startup clocks |

## Verification
The hardest case to reach is the boundary where shifting stops. The stopping point comes from a length field that is itself part of the stream being shifted, so it is only known once bit 35 has gone out. It may also fall inside a byte, before the header ends, or exactly on the header boundary. The stimulus sweeps lengths below, at and just past the 40-bit header and lengths that fall mid-byte. Each length runs in both bit orders, with and without source stalls. A model of the target reconstructs every rising-edge bit and raises its completion line a chosen number of clocks after the data. The same model drops the initialisation line at chosen edges in the header, in the body and during startup.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

    // Header layout in serial order (bit 0 is the first bit on the wire)
    localparam int HDR_BITS   = 40;
    localparam int LEN_W      = 24;
    localparam int CNT_W      = LEN_W + 1;
    // Position of the length field inside a 28-bit window ending at bit 39
    localparam int FIELD_HI   = 27;
    localparam int FIELD_LO   = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_INIT,
        ST_SHIFT,
        ST_STARTUP
    } ld_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       vld;
        logic [2:0] idx;
    } byte_slot_t;

    function automatic logic pick_bit(input logic [7:0] b, input logic [2:0] i,
                                      input logic lsb_first);
        return lsb_first ? b[i] : b[3'd7 - i];
    endfunction

endpackage

// File: rtl/cfg_ld_sync.sv
module cfg_ld_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= RESET_VAL;
                else     sr <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sr <= {STAGES{RESET_VAL}};
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/cfg_ld_phase.sv
module cfg_ld_phase #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || clear)  cnt <= '0;
        else if (run)      cnt <= tick ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/cfg_ld_hdr.sv
module cfg_ld_hdr
    import cfg_ld_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bit_done,
    input  logic bit_val,
    output logic last_bit
);
    logic [FIELD_HI-1:0] win;
    logic [FIELD_HI:0]   win_next;
    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    cnt_next;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    field;
    logic                at_hdr_end;
    logic [LEN_W-1:0]    len_eff;

    assign win_next   = {win, bit_val};
    assign field      = win_next[FIELD_HI:FIELD_LO];
    assign cnt_next   = cnt + 1'b1;
    assign at_hdr_end = (cnt_next == CNT_W'(HDR_BITS));
    assign len_eff    = at_hdr_end ? field : len_q;
    assign last_bit   = bit_done && (cnt_next >= CNT_W'(HDR_BITS))
                        && (cnt_next >= {1'b0, len_eff});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            win   <= '0;
            cnt   <= '0;
            len_q <= '0;
        end else if (bit_done) begin
            win <= win_next[FIELD_HI-1:0];
            cnt <= cnt_next;
            if (at_hdr_end) len_q <= field;
        end
    end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_ld_pkg::*;
#(
    parameter int HALF_CYC    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int LIMIT_W     = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               lsb_first,
    input  logic [LIMIT_W-1:0] startup_limit,
    input  logic               src_valid,
    input  logic [7:0]         src_data,
    output logic               src_ready,
    input  logic               cfg_init_n,
    input  logic               cfg_done,
    output logic               cfg_cclk,
    output logic               cfg_din,
    output logic               busy,
    output logic               done,
    output logic               init_error,
    output logic               timeout
);
    ld_state_e          state;
    byte_slot_t         slot;
    logic               order_q;
    logic               phase_hi;
    logic [LIMIT_W-1:0] su_cnt;
    logic               init_s, done_s;
    logic               tick, run, active, abort;
    logic               cur_bit, bit_done, last_bit;

    cfg_ld_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_init (
        .clk(clk), .rst(rst), .d(cfg_init_n), .q(init_s));

    cfg_ld_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_done (
        .clk(clk), .rst(rst), .d(cfg_done), .q(done_s));

    assign active = (state == ST_SHIFT) || (state == ST_STARTUP);
    assign abort  = active && !init_s;
    assign run    = ((state == ST_SHIFT) && (phase_hi || slot.vld))
                    || (state == ST_STARTUP);

    cfg_ld_phase #(.HALF_CYC(HALF_CYC)) u_phase (
        .clk(clk), .rst(rst), .clear(!active), .run(run), .tick(tick));

    assign cur_bit  = pick_bit(slot.data, slot.idx, order_q);
    assign bit_done = (state == ST_SHIFT) && phase_hi && tick && !abort;

    cfg_ld_hdr u_hdr (
        .clk(clk), .rst(rst), .clear(state == ST_IDLE),
        .bit_done(bit_done), .bit_val(cur_bit), .last_bit(last_bit));

    assign src_ready = (state == ST_SHIFT) && !slot.vld;
    assign cfg_din   = ((state == ST_SHIFT) && slot.vld) ? cur_bit : 1'b1;
    assign cfg_cclk  = phase_hi;
    assign busy      = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            slot       <= '0;
            order_q    <= 1'b0;
            phase_hi   <= 1'b0;
            su_cnt     <= '0;
            done       <= 1'b0;
            init_error <= 1'b0;
            timeout    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state      <= ST_WAIT_INIT;
                        order_q    <= lsb_first;
                        slot       <= '0;
                        su_cnt     <= '0;
                        phase_hi   <= 1'b0;
                        done       <= 1'b0;
                        init_error <= 1'b0;
                        timeout    <= 1'b0;
                    end
                end
                ST_WAIT_INIT: begin
                    if (init_s) state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (abort) begin
                        state      <= ST_IDLE;
                        init_error <= 1'b1;
                        phase_hi   <= 1'b0;
                        slot.vld   <= 1'b0;
                    end else begin
                        if (src_valid && src_ready)
                            slot <= '{data: src_data, vld: 1'b1, idx: 3'd0};
                        if (tick) begin
                            if (!phase_hi) begin
                                phase_hi <= 1'b1;
                            end else begin
                                phase_hi <= 1'b0;
                                if (last_bit) begin
                                    state    <= ST_STARTUP;
                                    slot.vld <= 1'b0;
                                end else if (slot.idx == 3'd7) begin
                                    slot.vld <= 1'b0;
                                end else begin
                                    slot.idx <= slot.idx + 3'd1;
                                end
                            end
                        end
                    end
                end
                ST_STARTUP: begin
                    if (abort) begin
                        state      <= ST_IDLE;
                        init_error <= 1'b1;
                        phase_hi   <= 1'b0;
                    end else if (!phase_hi && done_s) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else if (tick) begin
                        if (!phase_hi) begin
                            if (su_cnt >= startup_limit) begin
                                state   <= ST_IDLE;
                                timeout <= 1'b1;
                            end else begin
                                phase_hi <= 1'b1;
                                su_cnt   <= su_cnt + 1'b1;
                            end
                        end else begin
                            phase_hi <= 1'b0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_ld_checker.sv
module cfg_ld_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic src_ready,
    input logic cfg_cclk,
    input logic cfg_din,
    input logic busy,
    input logic done,
    input logic init_error,
    input logic timeout
);
    p_idle_clock_low_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cfg_cclk);

    p_rise_only_busy_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_cclk) |-> busy);

    p_din_hold_high_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_cclk |-> $stable(cfg_din));

    p_req_only_busy_r6: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> busy);

    p_finish_from_busy_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, init_error, timeout}));

    p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (!done && !init_error && !timeout && busy));
endmodule

bind cfg_serial_loader cfg_ld_checker u_chk (
    .clk(clk), .rst(rst), .start(start), .src_ready(src_ready),
    .cfg_cclk(cfg_cclk), .cfg_din(cfg_din), .busy(busy), .done(done),
    .init_error(init_error), .timeout(timeout));

// File: tb/sim_cfg_serial_loader.sv
`timescale 1ns/1ps
module sim_cfg_serial_loader;
    localparam int HALF = 2;
    localparam int LW   = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          lsb_first = 1'b0;
    logic [LW-1:0] startup_limit = 16'd100;
    logic          src_valid = 1'b0;
    logic [7:0]    src_data = 8'hFF;
    logic          src_ready;
    logic          cfg_init_n = 1'b0;
    logic          cfg_done = 1'b0;
    logic          cfg_cclk, cfg_din, busy, done, init_error, timeout;

    always #2 clk = ~clk;

    cfg_serial_loader #(.HALF_CYC(HALF), .SYNC_STAGES(2), .LIMIT_W(LW)) u0 (
        .clk(clk), .rst(rst), .start(start), .lsb_first(lsb_first),
        .startup_limit(startup_limit), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .cfg_init_n(cfg_init_n), .cfg_done(cfg_done),
        .cfg_cclk(cfg_cclk), .cfg_din(cfg_din), .busy(busy), .done(done),
        .init_error(init_error), .timeout(timeout));

    int n_checks = 0;
    int n_fail   = 0;

    // run configuration (written by the stimulus task only)
    logic [7:0] ser [0:31];
    logic [7:0] mem [0:31];
    int  exp_end = 0, done_at = -1, drop_at = -1, run_id = 0;
    bit  stall_mode = 0, init_rel = 0;

    // observation state (written by the monitor only)
    int   seen_id = 0, cyc = 0, ptr = 0, nacc = 0, rises = 0;
    int   data_mism = 0, startup_bad = 0, setup_bad = 0, age = 0;
    logic prev_cclk = 1'b0, prev_din = 1'b1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (run_id != seen_id) begin
            seen_id = run_id; ptr = 0; nacc = 0; rises = 0;
            data_mism = 0; startup_bad = 0; setup_bad = 0;
        end
        // byte source
        src_valid = stall_mode ? ((cyc % 3) != 0) : 1'b1;
        src_data  = mem[ptr % 32];
        if (src_valid && src_ready) begin ptr++; nacc++; end
        // target model
        if (cfg_din != prev_din) age = 1; else age++;
        if (cfg_cclk && !prev_cclk) begin
            if (age <= HALF) setup_bad++;
            if (rises < exp_end) begin
                if (cfg_din !== ser[rises / 8][7 - (rises % 8)]) data_mism++;
            end else if (cfg_din !== 1'b1) begin
                startup_bad++;
            end
            rises++;
        end
        cfg_done   = (done_at >= 0) && (rises >= done_at);
        cfg_init_n = init_rel && !((drop_at >= 0) && (rises >= drop_at));
        prev_cclk  = cfg_cclk;
        prev_din   = cfg_din;
    end

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7 - i];
        return r;
    endfunction

    task automatic run_load(input int len, input bit lsb, input bit stall,
                            input int k_done, input int drop, input int limit,
                            input bit restart);
        int end_bits, exp_rises, w, ex_bytes;
        bit restarted;
        logic [23:0] l24;
        end_bits = (len < 40) ? 40 : len;
        l24 = 24'(len);
        for (int i = 0; i < 32; i++) begin
            case (i)
                0: ser[i] = 8'hFF;
                1: ser[i] = {4'h2, l24[23:20]};
                2: ser[i] = l24[19:12];
                3: ser[i] = l24[11:4];
                4: ser[i] = {l24[3:0], 4'hF};
                default: ser[i] = 8'((i * 37 + len * 11 + 90) % 256);
            endcase
            mem[i] = lsb ? rev8(ser[i]) : ser[i];
        end
        @(negedge clk);
        exp_end = end_bits;
        done_at = (k_done >= 0) ? end_bits + k_done : -1;
        drop_at = drop;
        stall_mode = stall;
        init_rel = 0;
        startup_limit = LW'(limit);
        lsb_first = lsb;
        run_id++;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (12) @(negedge clk);
        // R2: nothing moves while the initialisation line is held low
        check(rises == 0 && nacc == 0 && busy, "R2 no clock/request before init release",
              rises + nacc, 0);
        // R10: flags cleared by an accepted start
        check(!done && !init_error && !timeout, "R10 flags cleared at start",
              {done, init_error, timeout}, 0);
        init_rel = 1;
        restarted = 0;
        for (w = 0; w < 20000 && busy; w++) begin
            @(negedge clk);
            if (restart && !restarted && rises >= 20) begin
                restarted = 1; start = 1'b1; lsb_first = !lsb;
                @(negedge clk); start = 1'b0; lsb_first = lsb;
            end
        end
        check(w < 20000, "R7 load finished", w, 20000);
        repeat (20) @(negedge clk);
        if (drop >= 0)        exp_rises = drop;
        else if (k_done >= 0) exp_rises = end_bits + k_done;
        else                  exp_rises = end_bits + limit;
        ex_bytes = (end_bits + 7) / 8;
        // R3, R4, R6: bit stream reconstructed at the target matches the serial view
        check(data_mism == 0, "R3/R4/R6 data bits", data_mism, 0);
        // R4, R7, R8, R9: total rising edges
        check(rises == exp_rises, "R4/R7/R9 rising edge count", rises, exp_rises);
        if (drop < 0)
            check(nacc == ex_bytes, "R4 bytes taken", nacc, ex_bytes);
        else
            check(nacc <= ex_bytes, "R8 bytes taken after fault", nacc, ex_bytes);
        check(setup_bad == 0, "R5 data setup before rise", setup_bad, 0);
        check(startup_bad == 0, "R7 startup data high", startup_bad, 0);
        check(done == (drop < 0 && k_done >= 0), "R7 done flag", done, drop < 0 && k_done >= 0);
        check(init_error == (drop >= 0), "R8 init_error flag", init_error, drop >= 0);
        check(timeout == (drop < 0 && k_done < 0), "R9 timeout flag", timeout,
              drop < 0 && k_done < 0);
        check(!busy && !cfg_cclk, "R10 idle after outcome", {busy, cfg_cclk}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!cfg_cclk && cfg_din && !src_ready && !busy && !done && !init_error && !timeout,
              "R1 reset state",
              {cfg_cclk, cfg_din, src_ready, busy, done, init_error, timeout}, 7'b0100000);
        //        len lsb stall k   drop lim restart
        run_load(  8, 0, 0,   3,   -1, 100, 0);   // R4 short length -> header only
        run_load( 40, 1, 0,   0,   -1, 100, 0);   // R7 zero startup clocks
        run_load( 41, 0, 1,   1,   -1, 100, 0);   // R6 stalls, mid-byte end
        run_load( 45, 1, 1,   5,   -1, 100, 0);   // R3 lsb first
        run_load( 64, 0, 0,   2,   -1, 100, 0);
        run_load( 97, 1, 1,   4,   -1, 100, 0);
        run_load( 77, 0, 0,  -1,   23, 100, 0);   // R8 fault inside header
        run_load( 60, 1, 1,  -1,   50, 100, 0);   // R8 fault in body
        run_load( 50, 0, 0,  -1,   52, 100, 0);   // R8 fault during startup
        run_load( 48, 0, 0,  -1,   -1,   6, 0);   // R9 timeout
        run_load( 48, 1, 1,  -1,   -1,   0, 0);   // R9 zero limit
        run_load( 70, 0, 0,   2,   -1, 100, 1);   // R10 start while busy ignored
        report();
        $finish;
    end
endmodule